// File: doc/BRIEF.md
# Configuration-Port Host Channel Controller

This block is one host-side channel for the byte-wide configuration port of a single target FPGA. A host reaches it through two 32-bit registers on a simple valid/ready register bus. One register holds control and status, and the other carries data. On the device side the block drives the port clock, the chip select, the read/write select, the program pin and the data byte. It samples the target's init and done pins and reads back the data byte.

The block has two modes, and both use the same pins. In configure mode, each data write sends one byte of a bitstream to the target. Software builds multi-byte command words itself by writing the bytes in sequence. After configuration, software can switch to FIFO mode. There the port becomes a plain 8-bit link: a data write pushes one byte into a FIFO inside the target, and a data read pulls one byte out of another. The occupancy of the remote FIFOs arrives on sideband inputs and is shown in the control register.

In FIFO mode, a falling edge on the target's init pin sets a sticky interrupt. The interrupt stays set until software clears it. The block holds no byte buffering, so a data access stalls the host until the port transfer is done.

Top module: `cfgport_chan`

## Requirements
- R1: After reset the control register reads MODE=0, PROG=1 and IRQ=0, and the port is idle: chip select high, port clock low, data pins not driven.
- R2: `req_reg`=1 selects the control register (channel offset 0x4) and `req_reg`=0 selects the data register (offset 0x0).
- R3: The control word layout, by LSB-indexed bit, is: [27] MODE (1 = FIFO mode), [26] PROG, [25] synchronized INIT_B (read-only), [24] synchronized DONE (read-only), [23:16] read FIFO count, [15:8] write FIFO space, [0] IRQ. All other bits read as zero.
- R4: The PROG pin follows control bit [26] from the clock after a control write, with no inversion.
- R5: A data write, in either mode, makes exactly one port transfer. During it chip select is low and read/write select is low, and `req_wdata[31:24]` is on the data pins at the single rising edge of the port clock. The host is held until chip select has been released.
- R6: A data read in FIFO mode with a non-zero read count makes one port transfer. During it the read/write select is high and the data pins are not driven. The byte sampled at the port-clock rising edge is returned in `rsp_rdata[31:24]`, and bits [23:0] read as zero.
- R7: A data read in FIFO mode with a read count of zero completes without any port-clock edge and returns zero.
- R8: A data read in configure mode completes without any port-clock edge and returns zero.
- R9: IRQ is set by a falling edge of the synchronized INIT_B only while MODE=1. INIT_B falling in configure mode has no effect, and INIT_B held low does not set it again.
- R10: IRQ stays set until a control write with bit [0]=0. A control write with bit [0]=1 does not set it.
- R11: The data pins are driven only while chip select and read/write select are both low.
- R12: The INIT_B, DONE and FIFO count fields follow the input pins and sideband inputs after a short synchronization delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | Register select: 1 control, 0 data |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access completes on this cycle's clock edge |
| rsp_rdata | output | 32 | Read data, valid while req_ready is high |
| dev_cclk | output | 1 | Port clock to the target |
| dev_d_o | output | 8 | Data byte toward the target |
| dev_d_oe | output | 1 | Output enable for the data pins |
| dev_d_i | input | 8 | Data byte from the target |
| dev_rdwr_b | output | 1 | Read/write select, low for write |
| dev_cs_b | output | 1 | Chip select, active low |
| dev_prog_b | output | 1 | Program pin, low deconfigures the target |
| dev_init_b | input | 1 | Init pin from the target |
| dev_done | input | 1 | Done pin from the target |
| fifo_rd_count | input | 8 | Bytes waiting in the target's read FIFO |
| fifo_wr_space | input | 8 | Free bytes in the target's write FIFO |
| irq | output | 1 | Channel interrupt |

## Verification
Two cases are hardest to reach from the ports. The first is telling a sticky, edge-set interrupt apart from a level-set one. The second is showing that a mode gate really blocks an INIT_B edge, rather than only delaying it. To cover both, the stimulus drops INIT_B in configure mode and then switches to FIFO mode while the pin is still high. It then makes a real falling edge and, with the pin held low, clears the bit. The interrupt must stay clear while the pin is still low. A bench monitor counts port-clock rising edges and records the byte and select level at each one. This shows that empty-FIFO reads and configure-mode reads make no transfer at all.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned BYTE_W = 8;

  // control word bit positions, LSB-indexed
  localparam int unsigned CTL_MODE     = 27;
  localparam int unsigned CTL_PROG     = 26;
  localparam int unsigned CTL_INIT     = 25;
  localparam int unsigned CTL_DONE     = 24;
  localparam int unsigned CTL_RCNT_LSB = 16;
  localparam int unsigned CTL_WSPC_LSB = 8;
  localparam int unsigned CTL_IRQ      = 0;
  localparam int unsigned DATA_LSB     = 24;

  localparam logic [BYTE_W-1:0] WSPC_RESET = 8'd129;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_SETUP,
    XF_HIGH,
    XF_DONE
  } xfer_state_e;
endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;
      assign sh_d = {sh_q[STAGES-2:0], d};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgport_xfer.sv
module cfgport_xfer
  import cfgport_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [BYTE_W-1:0] din,
  output logic              idle,
  output logic              done,
  output logic [BYTE_W-1:0] rbyte,
  output logic              cclk,
  output logic              cs_b,
  output logic              rdwr_b,
  output logic [BYTE_W-1:0] dout,
  output logic              oe
);
  localparam int unsigned      CNT_W    = $clog2(HALF_CYC) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              byte_en;
  logic              busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    byte_en = 1'b0;
    byte_d  = din;
    case (state_q)
      XF_IDLE: begin
        if (start) begin
          state_d = XF_SETUP;
          cnt_d   = '0;
          wr_d    = is_write;
          byte_en = 1'b1;
          byte_d  = wbyte;
        end
      end
      XF_SETUP: begin
        if (cnt_q == CNT_LAST) begin
          state_d = XF_HIGH;
          cnt_d   = '0;
          byte_en = !wr_q;          // sample read byte on the rising edge
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XF_HIGH: begin
        if (cnt_q == CNT_LAST) state_d = XF_DONE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign busy   = (state_q == XF_SETUP) || (state_q == XF_HIGH);
  assign idle   = (state_q == XF_IDLE);
  assign done   = (state_q == XF_DONE);
  assign cclk   = (state_q == XF_HIGH);
  assign cs_b   = !busy;
  assign rdwr_b = !(busy && wr_q);
  assign oe     = busy && wr_q;
  assign dout   = byte_q;
  assign rbyte  = byte_q;

  // R5: chip select was already low in the cycle before each port-clock rise
  a_r5_select_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $past(!cs_b));

  // R5: the driven byte does not change while the pins stay driven
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(dout));
endmodule

// File: rtl/cfgport_irq.sv
module cfgport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic init_sync,
  input  logic clr,
  output logic irq
);
  logic prev_q;
  logic irq_q, irq_d;
  logic fall;

  assign fall  = prev_q && !init_sync;
  assign irq_d = (fifo_mode && fall) || (irq_q && !clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= init_sync;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  // R9: the interrupt only rises out of a FIFO-mode cycle
  a_r9_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(fifo_mode));

  // R10: without a clear the interrupt is held
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
endmodule

// File: rtl/cfgport_chan.sv
module cfgport_chan
  import cfgport_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_reg,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              dev_cclk,
  output logic [BYTE_W-1:0] dev_d_o,
  output logic              dev_d_oe,
  input  logic [BYTE_W-1:0] dev_d_i,
  output logic              dev_rdwr_b,
  output logic              dev_cs_b,
  output logic              dev_prog_b,
  input  logic              dev_init_b,
  input  logic              dev_done,
  input  logic [BYTE_W-1:0] fifo_rd_count,
  input  logic [BYTE_W-1:0] fifo_wr_space,
  output logic              irq
);
  logic              mode_q, mode_d;
  logic              prog_q, prog_d;
  logic [BYTE_W-1:0] rcnt_q, wspc_q;
  logic              init_s, done_s;
  logic              ctl_wr, irq_clr;
  logic              rd_skip, xf_start, xf_idle, xf_done;
  logic [BYTE_W-1:0] xf_rbyte;
  logic [BUS_W-1:0]  ctl_word;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_LSB-1:CTL_IRQ+1];

  cfgport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d(dev_init_b), .q(init_s));
  cfgport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(dev_done), .q(done_s));

  // data reads that never touch the port
  assign rd_skip  = !req_write && (!mode_q || (rcnt_q == '0));
  assign xf_start = req_valid && !req_reg && !rd_skip && xf_idle;

  assign req_ready = req_valid && (req_reg || (xf_idle && rd_skip && !req_reg) || xf_done);
  assign ctl_wr    = req_valid && req_ready && req_reg && req_write;
  assign irq_clr   = ctl_wr && !req_wdata[CTL_IRQ];

  always_comb begin
    mode_d = mode_q;
    prog_d = prog_q;
    if (ctl_wr) begin
      mode_d = req_wdata[CTL_MODE];
      prog_d = req_wdata[CTL_PROG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      prog_q <= 1'b1;
      rcnt_q <= '0;
      wspc_q <= WSPC_RESET;
    end else begin
      mode_q <= mode_d;
      prog_q <= prog_d;
      rcnt_q <= fifo_rd_count;
      wspc_q <= fifo_wr_space;
    end
  end

  cfgport_xfer #(.HALF_CYC(HALF_CYC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xf_start), .is_write(req_write),
    .wbyte(req_wdata[DATA_LSB +: BYTE_W]), .din(dev_d_i),
    .idle(xf_idle), .done(xf_done), .rbyte(xf_rbyte),
    .cclk(dev_cclk), .cs_b(dev_cs_b), .rdwr_b(dev_rdwr_b),
    .dout(dev_d_o), .oe(dev_d_oe));

  cfgport_irq u_irq (
    .clk(clk), .rst_n(rst_n), .fifo_mode(mode_q), .init_sync(init_s),
    .clr(irq_clr), .irq(irq));

  always_comb begin
    ctl_word                            = '0;
    ctl_word[CTL_MODE]                  = mode_q;
    ctl_word[CTL_PROG]                  = prog_q;
    ctl_word[CTL_INIT]                  = init_s;
    ctl_word[CTL_DONE]                  = done_s;
    ctl_word[CTL_RCNT_LSB +: BYTE_W]    = rcnt_q;
    ctl_word[CTL_WSPC_LSB +: BYTE_W]    = wspc_q;
    ctl_word[CTL_IRQ]                   = irq;
  end

  always_comb begin
    rsp_rdata = '0;
    if (req_reg)
      rsp_rdata = ctl_word;
    else if (xf_done && !req_write)
      rsp_rdata[DATA_LSB +: BYTE_W] = xf_rbyte;
  end

  assign dev_prog_b = prog_q;

  // R4: the program pin takes the written bit one clock after a control write
  a_r4_prog_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (dev_prog_b == $past(req_wdata[CTL_PROG])));

  // R8: a data read in configure mode leaves chip select released
  a_r8_cfg_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_reg && !req_write && !mode_q) |=> dev_cs_b);
endmodule

// File: tb/cfgport_chan_tb.sv
`timescale 1ns/1ps
module cfgport_chan_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_reg;
  logic [31:0] req_wdata;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        dev_cclk, dev_d_oe, dev_rdwr_b, dev_cs_b, dev_prog_b;
  logic [7:0]  dev_d_o, dev_d_i;
  logic        dev_init_b, dev_done;
  logic [7:0]  fifo_rd_count, fifo_wr_space;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rise_cnt = 0;
  logic [7:0] rise_byte = '0;
  logic       rise_rdwr = 1'b1;
  logic       bad_oe = 1'b0;

  cfgport_chan dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .dev_cclk(dev_cclk), .dev_d_o(dev_d_o),
    .dev_d_oe(dev_d_oe), .dev_d_i(dev_d_i), .dev_rdwr_b(dev_rdwr_b),
    .dev_cs_b(dev_cs_b), .dev_prog_b(dev_prog_b), .dev_init_b(dev_init_b),
    .dev_done(dev_done), .fifo_rd_count(fifo_rd_count),
    .fifo_wr_space(fifo_wr_space), .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // port monitor: edges, byte and select level at each rise
  always @(posedge dev_cclk) begin
    rise_cnt  = rise_cnt + 1;
    rise_byte = dev_d_o;
    rise_rdwr = dev_rdwr_b;
  end

  always @(negedge clk)
    if (rst_n && dev_d_oe && (dev_cs_b || dev_rdwr_b)) bad_oe = 1'b1;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic ctl, input logic [31:0] wd,
                        output logic [31:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = ctl; req_wdata = wd;
    n = 0;
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (n >= 100) check("R5 handshake timeout", 32'd1, 32'd0);
    rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;     // 0 ctl wr, 1 ctl rd, 2 data wr, 3 data rd
    logic [31:0] wd;
    logic [7:0]  rcnt;
    logic [7:0]  din;
    logic [31:0] exp;
    logic [1:0]  edges;
    logic [3:0]  req;
  } vec_t;

  // R3 ctl write/read, R12 status fields, R5 writes, R6 read, R7 empty read, R8 configure read
  localparam vec_t VECS [10] = '{
    '{2'd0, 32'h0C000000, 8'd5, 8'h00, 32'h0,        2'd0, 4'd3},
    '{2'd1, 32'h0,        8'd5, 8'h00, 32'h0F052000, 2'd0, 4'd12},
    '{2'd2, 32'hA5000000, 8'd5, 8'h00, 32'h0,        2'd1, 4'd5},
    '{2'd2, 32'h3C123456, 8'd5, 8'h00, 32'h0,        2'd1, 4'd5},
    '{2'd3, 32'h0,        8'd5, 8'h5A, 32'h5A000000, 2'd1, 4'd6},
    '{2'd3, 32'h0,        8'd0, 8'h77, 32'h0,        2'd0, 4'd7},
    '{2'd0, 32'h04000000, 8'd0, 8'h00, 32'h0,        2'd0, 4'd3},
    '{2'd3, 32'h0,        8'd5, 8'h11, 32'h0,        2'd0, 4'd8},
    '{2'd2, 32'hC3FFFFFF, 8'd5, 8'h00, 32'h0,        2'd1, 4'd5},
    '{2'd1, 32'h0,        8'd0, 8'h00, 32'h07002000, 2'd0, 4'd12}
  };

  initial begin
    logic [31:0] rd;
    int base;
    req_valid = 0; req_write = 0; req_reg = 0; req_wdata = '0;
    dev_d_i = '0; dev_init_b = 1'b1; dev_done = 1'b0;
    fifo_rd_count = 8'd0; fifo_wr_space = 8'd129;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the pins
    check("R1 cs_b", {31'd0, dev_cs_b}, 32'd1);
    check("R1 cclk", {31'd0, dev_cclk}, 32'd0);
    check("R1 oe", {31'd0, dev_d_oe}, 32'd0);
    check("R1 prog", {31'd0, dev_prog_b}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    access(1'b0, 1'b1, 32'h0, rd);           // R2 req_reg=1 is control
    check("R1 control word", rd, 32'h06008100);

    fifo_wr_space = 8'h20; dev_done = 1'b1;
    // R4: program pin follows bit 26
    access(1'b1, 1'b1, 32'h00000000, rd);
    check("R4 prog low", {31'd0, dev_prog_b}, 32'd0);
    access(1'b0, 1'b1, 32'h0, rd);
    check("R3 control readback", rd, 32'h03002000);
    access(1'b1, 1'b1, 32'h04000000, rd);
    check("R4 prog high", {31'd0, dev_prog_b}, 32'd1);

    for (int i = 0; i < 10; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      fifo_rd_count = VECS[i].rcnt;
      dev_d_i       = VECS[i].din;
      repeat (3) @(negedge clk);
      base = rise_cnt;
      access(VECS[i].op[1] == 1'b0 ? VECS[i].op == 2'd0 : VECS[i].op == 2'd2,
             !VECS[i].op[1], VECS[i].wd, rd);
      if (VECS[i].op[0]) check(tag, rd, VECS[i].exp);
      check({tag, " edges"}, 32'(rise_cnt - base), {30'd0, VECS[i].edges});
      if (VECS[i].op == 2'd2) begin
        check({tag, " byte"}, {24'd0, rise_byte}, {24'd0, VECS[i].wd[31:24]});
        check({tag, " rdwr"}, {31'd0, rise_rdwr}, 32'd0);
      end
      if (VECS[i].op == 2'd3 && VECS[i].edges == 2'd1)
        check({tag, " rdwr"}, {31'd0, rise_rdwr}, 32'd1);
    end

    // R9: INIT_B edge in configure mode is ignored
    dev_init_b = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 cfg edge ignored", {31'd0, irq}, 32'd0);
    dev_init_b = 1'b1;
    repeat (6) @(negedge clk);
    access(1'b1, 1'b1, 32'h0C000000, rd);
    repeat (3) @(negedge clk);
    check("R9 no late set", {31'd0, irq}, 32'd0);
    dev_init_b = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 fifo edge sets", {31'd0, irq}, 32'd1);
    access(1'b0, 1'b1, 32'h0, rd);
    check("R9 irq bit", rd, 32'h0D002001);
    // R10: writing 1 keeps it, writing 0 clears it
    access(1'b1, 1'b1, 32'h0C000001, rd);
    check("R10 write one keeps", {31'd0, irq}, 32'd1);
    access(1'b1, 1'b1, 32'h0C000000, rd);
    check("R10 clear", {31'd0, irq}, 32'd0);
    repeat (6) @(negedge clk);
    check("R9 level does not reset", {31'd0, irq}, 32'd0);

    check("R11 oe only in write select", {31'd0, bad_oe}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule